// File: doc/BRIEF.md
# Eight-Opcode Accumulator Stack Core

This core runs programs made of 3-bit opcodes. An opcode has no operand field, so the whole instruction set is eight operations. They act on an accumulator, a data register, a stack pointer into a small internal stack, and an instruction pointer. While the core is running it completes one instruction in every clock cycle. It fetches each opcode through a read-only program port. That port takes an address out and returns the opcode in the same cycle.

No instruction carries an immediate value. A program builds a constant one bit at a time by clearing the accumulator, incrementing it and rotating it left. The data register can only be reached by exchanging it with the accumulator. Both jumps are register-indirect: they take their destination from the data register. A jump whose destination is address zero is not a branch. It opens a system-call gate instead. The core stops fetching, raises a request, and shows the stack pointer and the top-of-stack entry so that an outside agent can read the call's arguments. After an acknowledge, the core continues at the address that follows the jump.

Top module: `acc_stack_core`

## Requirements
- R1: While reset is held and just after it is released, the accumulator, the data register and the stack pointer are 0, every stack entry is 0, the fetch address is 1 and there is no call request.
- R2: Opcode 0 loads 0 into the accumulator. Opcode 1 adds 1 to the accumulator, modulo 2^DATA_W.
- R3: Opcode 2 rotates the accumulator left by one bit, and its top bit moves into bit 0.
- R4: Opcode 3 exchanges the contents of the accumulator and the data register.
- R5: Opcode 4 first adds 1 to the stack pointer and then writes the accumulator into the entry at that new pointer. The new entry appears on the top-of-stack output.
- R6: Opcode 5 loads the accumulator from the entry at the current stack pointer and then subtracts 1 from the stack pointer.
- R7: Opcode 6 with an accumulator of 0 makes the next fetch come from the address held in the data register. With any other accumulator value the next fetch comes from the current address plus 1.
- R8: Opcode 7 always makes the next fetch come from the address held in the data register.
- R9: Opcodes 0 to 5 advance the fetch address by exactly 1.
- R10: A taken jump (opcode 6 or 7) whose destination is address 0 raises the call request. While the request is up and acknowledge is low, the core executes nothing and keeps every register unchanged. During that time the stack pointer and the top-of-stack entry stay visible on their outputs.
- R11: An acknowledge seen while the request is up drops the request in the next cycle. The fetch address is then the jump's own address plus 1, and execution resumes from there.
- R12: The stack pointer wraps modulo STACK_DEPTH (a power of two) in both directions. A seventeenth push into a 16-entry stack overwrites entry 1, and a pop at pointer 0 leaves the pointer at 15.
- R13: The sequence 0,1,2,1,2,2,1 starting from reset leaves 13 in the accumulator after seven cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| prog_addr | output | ADDR_W | Address of the opcode to fetch |
| prog_op | input | 3 | Opcode at prog_addr, same cycle |
| sys_req | output | 1 | A system call is pending and the core is stalled |
| sys_ack | input | 1 | The system call is done; resume |
| sys_sp | output | SP_W | Current stack pointer |
| sys_tos | output | DATA_W | Stack entry at the current stack pointer |
| acc_q | output | DATA_W | Accumulator contents |
| dat_q | output | DATA_W | Data register contents |

## Verification
The hardest case to reach from the ports is the call gate. To enter it, a program must first clear the accumulator, exchange that zero into the data register, and only then execute a taken jump. It must also do this while the stack holds known arguments. A directed program does exactly this and keeps acknowledge low for several cycles so the stall can be checked. Random programs then run in lockstep against a bench model while acknowledge is driven randomly. Because the data register is zero after reset, those programs hit the gate often, and they also hit it with acknowledge arriving in the very first stalled cycle. Stack wrap is reached with a directed run of seventeen pushes followed by pops below zero.

// File: rtl/acc_stack_core.sv
module acc_stack_core #(
  parameter int DATA_W      = 16,
  parameter int ADDR_W      = 16,
  parameter int STACK_DEPTH = 16,
  localparam int SP_W       = $clog2(STACK_DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [ADDR_W-1:0] prog_addr,
  input  logic [2:0]        prog_op,
  output logic              sys_req,
  input  logic              sys_ack,
  output logic [SP_W-1:0]   sys_sp,
  output logic [DATA_W-1:0] sys_tos,
  output logic [DATA_W-1:0] acc_q,
  output logic [DATA_W-1:0] dat_q
);

  localparam logic [2:0] OP_CLR  = 3'd0;
  localparam logic [2:0] OP_INC  = 3'd1;
  localparam logic [2:0] OP_ROT  = 3'd2;
  localparam logic [2:0] OP_XCH  = 3'd3;
  localparam logic [2:0] OP_PUSH = 3'd4;
  localparam logic [2:0] OP_POP  = 3'd5;
  localparam logic [2:0] OP_JZ   = 3'd6;
  localparam logic [2:0] OP_JMP  = 3'd7;

  logic [DATA_W-1:0] acc, dat;
  logic [SP_W-1:0]   sp;
  logic [ADDR_W-1:0] ip;
  logic              req;
  logic [DATA_W-1:0] stk [STACK_DEPTH];

  wire               taken  = (prog_op == OP_JMP) || (prog_op == OP_JZ && acc == '0);
  wire [ADDR_W-1:0]  bias   = ADDR_W'(dat) - 1'b1;
  wire [ADDR_W-1:0]  dest   = bias + 1'b1;
  wire               gate   = taken && (dest == '0);
  wire [SP_W-1:0]    sp_up  = sp + 1'b1;
  wire [ADDR_W-1:0]  ip_seq = ip + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc <= '0;
      dat <= '0;
      sp  <= '0;
      ip  <= ADDR_W'(1);
      req <= 1'b0;
      for (int i = 0; i < STACK_DEPTH; i++) stk[i] <= '0;
    end else if (req) begin
      if (sys_ack) req <= 1'b0;
    end else begin
      ip <= ip_seq;
      unique case (prog_op)
        OP_CLR:  acc <= '0;
        OP_INC:  acc <= acc + 1'b1;
        OP_ROT:  acc <= {acc[DATA_W-2:0], acc[DATA_W-1]};
        OP_XCH: begin
          acc <= dat;
          dat <= acc;
        end
        OP_PUSH: begin
          sp        <= sp_up;
          stk[sp_up] <= acc;
        end
        OP_POP: begin
          acc <= stk[sp];
          sp  <= sp - 1'b1;
        end
        default: begin
          if (gate)       req <= 1'b1;
          else if (taken) ip  <= dest;
        end
      endcase
    end
  end

  assign prog_addr = ip;
  assign sys_req   = req;
  assign sys_sp    = sp;
  assign sys_tos   = stk[sp];
  assign acc_q     = acc;
  assign dat_q     = dat;

endmodule

// File: rtl/acc_stack_core_chk.sv
module acc_stack_core_chk #(
  parameter int DATA_W      = 16,
  parameter int ADDR_W      = 16,
  parameter int STACK_DEPTH = 16,
  localparam int SP_W       = $clog2(STACK_DEPTH)
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] prog_addr,
  input logic [2:0]        prog_op,
  input logic              sys_req,
  input logic              sys_ack,
  input logic [SP_W-1:0]   sys_sp,
  input logic [DATA_W-1:0] sys_tos,
  input logic [DATA_W-1:0] acc_q,
  input logic [DATA_W-1:0] dat_q
);

  AST_CLR_ZEROES: assert property (@(posedge clk) disable iff (!rst_n)
    !sys_req && prog_op == 3'd0 |=> acc_q == '0); // R2
  AST_INC_ADDS: assert property (@(posedge clk) disable iff (!rst_n)
    !sys_req && prog_op == 3'd1 |=> acc_q == DATA_W'($past(acc_q) + 1'b1)); // R2
  AST_ROT_WRAPS: assert property (@(posedge clk) disable iff (!rst_n)
    !sys_req && prog_op == 3'd2 |=> acc_q == {$past(acc_q[DATA_W-2:0]), $past(acc_q[DATA_W-1])}); // R3
  AST_XCH_SWAPS: assert property (@(posedge clk) disable iff (!rst_n)
    !sys_req && prog_op == 3'd3 |=> acc_q == $past(dat_q) && dat_q == $past(acc_q)); // R4
  AST_PUSH_WRITES: assert property (@(posedge clk) disable iff (!rst_n)
    !sys_req && prog_op == 3'd4 |=> sys_sp == SP_W'($past(sys_sp) + 1'b1) && sys_tos == $past(acc_q)); // R5
  AST_JMP_DEST: assert property (@(posedge clk) disable iff (!rst_n)
    !sys_req && prog_op == 3'd7 && ADDR_W'(dat_q) != '0 |=> !sys_req && prog_addr == ADDR_W'($past(dat_q))); // R8
  AST_GATE_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
    !sys_req && prog_op == 3'd7 && ADDR_W'(dat_q) == '0 |=> sys_req); // R10
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    sys_req && !sys_ack |=> sys_req && $stable(prog_addr) && $stable(acc_q) && $stable(dat_q) && $stable(sys_sp)); // R10
  AST_ACK_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    sys_req && sys_ack |=> !sys_req && $stable(prog_addr)); // R11

endmodule

bind acc_stack_core acc_stack_core_chk #(
  .DATA_W(DATA_W), .ADDR_W(ADDR_W), .STACK_DEPTH(STACK_DEPTH)
) u_chk (.*);

// File: tb/acc_stack_core_test.sv
`timescale 1ns/1ps
module acc_stack_core_test;
  localparam int DW = 16;
  localparam int AW = 16;
  localparam int DEPTH = 16;
  localparam int SPW = $clog2(DEPTH);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sys_ack = 1'b0;
  logic [AW-1:0] prog_addr;
  logic [2:0] prog_op;
  logic sys_req;
  logic [SPW-1:0] sys_sp;
  logic [DW-1:0] sys_tos, acc_q, dat_q;
  logic [2:0] prog [256];

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [DW-1:0] m_acc, m_dat;
  logic [SPW-1:0] m_sp;
  logic [AW-1:0] m_ip;
  logic m_req;
  logic [DW-1:0] m_stk [DEPTH];
  string tag;

  always #4 clk = ~clk;
  assign prog_op = prog[prog_addr[7:0]];

  acc_stack_core #(.DATA_W(DW), .ADDR_W(AW), .STACK_DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .prog_addr(prog_addr), .prog_op(prog_op),
    .sys_req(sys_req), .sys_ack(sys_ack), .sys_sp(sys_sp), .sys_tos(sys_tos),
    .acc_q(acc_q), .dat_q(dat_q));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic compare();
    bit ok;
    ok = acc_q === m_acc && dat_q === m_dat && sys_sp === m_sp &&
         prog_addr === m_ip && sys_req === m_req && sys_tos === m_stk[m_sp];
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual acc=%h dat=%h sp=%h ip=%h req=%b tos=%h expected acc=%h dat=%h sp=%h ip=%h req=%b tos=%h",
               tag, acc_q, dat_q, sys_sp, prog_addr, sys_req, sys_tos,
               m_acc, m_dat, m_sp, m_ip, m_req, m_stk[m_sp]);
    end
  endtask

  task automatic model_step(input logic ack);
    logic [2:0] op;
    logic [DW-1:0] t;
    bit jmp;
    op = prog[m_ip[7:0]];
    if (m_req) begin
      if (ack) begin m_req = 0; tag = "R11"; end
      else tag = "R10";
    end else begin
      case (op)
        3'd0: begin m_acc = '0; tag = "R2 R9"; end
        3'd1: begin m_acc = m_acc + 1'b1; tag = "R2 R9"; end
        3'd2: begin m_acc = {m_acc[DW-2:0], m_acc[DW-1]}; tag = "R3 R9"; end
        3'd3: begin t = m_acc; m_acc = m_dat; m_dat = t; tag = "R4 R9"; end
        3'd4: begin m_sp = m_sp + 1'b1; m_stk[m_sp] = m_acc; tag = "R5 R9 R12"; end
        3'd5: begin m_acc = m_stk[m_sp]; m_sp = m_sp - 1'b1; tag = "R6 R9 R12"; end
        default: tag = (op == 3'd6) ? "R7" : "R8";
      endcase
      jmp = (op == 3'd7) || (op == 3'd6 && m_acc == '0);
      if (jmp && m_dat == '0) begin m_req = 1; m_ip = m_ip + 1'b1; tag = "R10"; end
      else if (jmp) m_ip = AW'(m_dat);
      else m_ip = m_ip + 1'b1;
    end
  endtask

  task automatic step(input logic ack);
    sys_ack = ack;
    model_step(ack);
    @(negedge clk);
    compare();
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step(1'b0);
  endtask

  task automatic clear_prog();
    for (int i = 0; i < 256; i++) prog[i] = 3'd0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    sys_ack = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    m_acc = '0; m_dat = '0; m_sp = '0; m_ip = AW'(1); m_req = 0;
    for (int i = 0; i < DEPTH; i++) m_stk[i] = '0;
    tag = "R1";
    compare();
  endtask

  initial begin
    void'($urandom(32'd2024));
    clear_prog();
    @(negedge clk);
    do_reset();
    chk(acc_q == 0 && dat_q == 0 && sys_sp == 0 && prog_addr == 1 && !sys_req, "R1", prog_addr, 1);

    // R13: constant 13 built bit by bit
    clear_prog();
    prog[1] = 0; prog[2] = 1; prog[3] = 2; prog[4] = 1; prog[5] = 2; prog[6] = 2; prog[7] = 1;
    do_reset();
    run(7);
    chk(acc_q == 13, "R13", acc_q, 13);

    // R7 R8: jumps with nonzero destination
    clear_prog();
    prog[1] = 0; prog[2] = 1; prog[3] = 2; prog[4] = 1; prog[5] = 2; prog[6] = 2;
    prog[7] = 3; prog[8] = 6; prog[12] = 1; prog[13] = 6; prog[14] = 7;
    do_reset();
    run(8);
    chk(prog_addr == 12 && dat_q == 12, "R7", prog_addr, 12);
    run(2);
    chk(prog_addr == 14, "R7", prog_addr, 14);
    run(1);
    chk(prog_addr == 12 && !sys_req, "R8", prog_addr, 12);

    // R10 R11: system-call gate with delayed acknowledge
    clear_prog();
    prog[1] = 1; prog[2] = 3; prog[3] = 0; prog[4] = 3; prog[5] = 4; prog[6] = 7; prog[7] = 6;
    do_reset();
    run(6);
    chk(sys_req == 1, "R10", sys_req, 1);
    run(4);
    chk(sys_req && sys_sp == 1 && sys_tos == 1 && acc_q == 1 && prog_addr == 7, "R10", sys_tos, 1);
    step(1'b1);
    chk(!sys_req && prog_addr == 7, "R11", prog_addr, 7);
    run(1);
    chk(prog_addr == 8, "R11", prog_addr, 8);

    // R12: push wrap and pop underflow
    clear_prog();
    for (int i = 0; i < 17; i++) begin prog[1 + 2*i] = 1; prog[2 + 2*i] = 4; end
    prog[35] = 5; prog[36] = 5;
    do_reset();
    run(34);
    chk(sys_sp == 1 && sys_tos == 17, "R12", sys_tos, 17);
    run(2);
    chk(acc_q == 16 && sys_sp == 15, "R12", sys_sp, 15);

    // R3: rotate carries top bit into bit 0
    clear_prog();
    prog[1] = 1;
    for (int i = 2; i < 17; i++) prog[i] = 2;
    prog[17] = 1; prog[18] = 2;
    do_reset();
    run(16);
    chk(acc_q == 16'h8000, "R3", acc_q, 16'h8000);
    run(2);
    chk(acc_q == 16'h0003, "R3", acc_q, 16'h0003);

    // Random programs in lockstep with the model, random acknowledge
    for (int r = 0; r < 6; r++) begin
      for (int i = 0; i < 256; i++) prog[i] = 3'($urandom());
      do_reset();
      for (int c = 0; c < 3000; c++) step(($urandom() % 3) == 0);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule